// File: doc/BRIEF.md
# Per-Flow Express-Lane Prioritizer

This block sits in front of an egress queue and decides, packet by packet, whether a descriptor enters a small express FIFO or the bulk normal FIFO. Every arriving descriptor carries a flow hash. The hash is folded into an index into a table of per-flow packet counters. A flow whose counter is still below a programmable packet threshold is steered to the express FIFO. The counter then advances. Once the counter reaches the threshold, later packets of that flow queue behind the bulk traffic. The first few packets of every flow therefore skip the bulk queue.

A strict-priority scheduler drains the express FIFO before the normal FIFO. Each table entry carries an idle timer. The timer clears the entry after a programmable number of quiet cycles, so a flow that returns later is treated as new. When the express FIFO is full, a packet that qualifies for it falls back to the normal FIFO and is not dropped. Both lanes expose their occupancy, and the block counts the packets it places in each lane.

Top module: `express_lane_steer`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, in_ready is 1, both occupancies are 0, both lane counters are 0, and every flow counter is 0.
- R2: The table index is the XOR fold of the hash: hash bit b is XORed into index bit (b mod IDX_W). An accepted packet whose indexed counter is below prio_threshold goes to the express lane. Otherwise it goes to the normal lane. Each accepted packet advances its counter by one.
- R3: When the express lane holds a descriptor, out_desc shows the express head with out_express=1. The normal lane is served only when the express lane is empty, and then out_express=0.
- R4: Within each lane, descriptors leave in the order they were accepted.
- R5: A flow counter saturates at the prio_threshold in force when it is updated. If the threshold is later raised, the flow again receives express placement until its counter reaches the new value.
- R6: An entry with no accepted packet for idle_limit consecutive cycles is cleared. A packet accepted exactly idle_limit cycles after the previous one on the same index still sees the kept count. A packet accepted idle_limit+1 cycles after it sees a cleared count. idle_limit is expected to be nonzero.
- R7: A packet that qualifies for express while the express FIFO is full is placed in the normal FIFO.
- R8: in_ready is 0 exactly when the normal FIFO is full. While in_ready is 0, in_valid has no effect on the occupancies, the counters or the flow table.
- R9: exp_occ and norm_occ give the current entry count of each lane. exp_sent and norm_sent count the packets placed in each lane, and at most one of them advances per cycle.
- R10: An enqueue and a dequeue on the same lane in the same cycle leave its occupancy unchanged, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Arriving descriptor is valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_desc | input | DESC_W | Packet descriptor |
| in_hash | input | HASH_W | Flow hash of the packet |
| prio_threshold | input | CNT_W | Number of packets per flow given express placement |
| idle_limit | input | AGE_W | Quiet cycles before a flow entry is cleared |
| out_ready | input | 1 | Downstream takes the presented descriptor |
| out_valid | output | 1 | A descriptor is presented |
| out_desc | output | DESC_W | Presented descriptor |
| out_express | output | 1 | Presented descriptor comes from the express lane |
| exp_occ | output | clog2(EXP_DEPTH+1) | Express FIFO occupancy |
| norm_occ | output | clog2(NORM_DEPTH+1) | Normal FIFO occupancy |
| exp_sent | output | STAT_W | Packets placed in the express lane |
| norm_sent | output | STAT_W | Packets placed in the normal lane |

## Verification
Two pairs of events can fall in the same cycle. The first is an enqueue and a dequeue on the same lane. The bench provokes it by streaming back-to-back packets with out_ready held high. It then judges that the occupancy stays at one while every descriptor leaves in order. The second is a packet hit and an idle-timer expiry on the same table entry. The bench places a packet exactly idle_limit cycles after the previous one, where the kept count must win and send it to the normal lane. It then places one a cycle later, where the cleared entry must send it to the express lane.

// File: rtl/xl_pkg.sv
// Shared types for the express-lane prioritizer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xl_pkg;
    typedef enum logic {
        LANE_NORMAL  = 1'b0,
        LANE_EXPRESS = 1'b1
    } lane_e;
endpackage

// File: rtl/xl_fifo.sv
// Synchronous first-word-fall-through FIFO with occupancy output.
// Assumes DEPTH is a power of two, and that the caller never pushes when
// full and never pops when empty. Push and pop may coincide.
module xl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign empty = (occ == '0);
    assign full  = (occ == OCC_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            if (push && !pop)      occ <= occ + OCC_W'(1);
            else if (pop && !push) occ <= occ - OCC_W'(1);
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_occ_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (occ == $past(occ)));
endmodule

// File: rtl/xl_flow_table.sv
// Table of per-flow packet counters with idle aging.
// The read is combinational on the index. On a lookup, the indexed counter
// advances, saturating at the threshold. An entry that sees no lookup for
// idle_limit consecutive cycles is cleared. A lookup wins over expiry in
// the same cycle. Assumes idle_limit is nonzero.
module xl_flow_table #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 8,
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] threshold,
    input  logic [AGE_W-1:0] idle_limit,
    output logic             qualify
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [CNT_W-1:0] cnt_q [ENTRIES];
    logic [AGE_W-1:0] age_q [ENTRIES];
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] nxt_cnt;

    // Read the indexed counter and form its saturating successor.
    always_comb begin
        cur_cnt = cnt_q[idx];
        qualify = (cur_cnt < threshold);
        nxt_cnt = qualify ? (cur_cnt + CNT_W'(1)) : threshold;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic hit;
        assign hit = lookup && (idx == IDX_W'(i));

        // Per-entry counter update and idle timer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
                age_q[i] <= '0;
            end else if (hit) begin
                cnt_q[i] <= nxt_cnt;
                age_q[i] <= '0;
            end else if (cnt_q[i] != '0) begin
                if (age_q[i] == idle_limit - AGE_W'(1)) begin
                    cnt_q[i] <= '0;
                    age_q[i] <= '0;
                end else begin
                    age_q[i] <= age_q[i] + AGE_W'(1);
                end
            end
        end

        p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && (cnt_q[i] < threshold)) |=>
                (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));
        p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && (cnt_q[i] == '0)) |=> (cnt_q[i] == '0));
    end
endmodule

// File: rtl/xl_sched.sv
// Strict-priority two-lane dequeue scheduler.
// Presents the express head whenever the express lane is non-empty,
// otherwise the normal head, and pops the selected lane on a handshake.
module xl_sched
    import xl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         exp_empty,
    input  logic         norm_empty,
    input  logic [W-1:0] exp_head,
    input  logic [W-1:0] norm_head,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_desc,
    output lane_e        out_lane,
    output logic         exp_pop,
    output logic         norm_pop
);
    // Lane selection and pop generation.
    always_comb begin
        out_valid = !exp_empty || !norm_empty;
        out_lane  = exp_empty ? LANE_NORMAL : LANE_EXPRESS;
        out_desc  = (out_lane == LANE_EXPRESS) ? exp_head : norm_head;
        exp_pop   = out_valid && out_ready && (out_lane == LANE_EXPRESS);
        norm_pop  = out_valid && out_ready && (out_lane == LANE_NORMAL);
    end
endmodule

// File: rtl/express_lane_steer.sv
// Per-flow express-lane prioritizer, top level.
// Folds the flow hash into a table index and steers each accepted
// descriptor to the express FIFO while its flow count is below the
// threshold. When the express FIFO is full, it falls back to the normal
// FIFO. Drains with strict express priority. Assumes FIFO depths are
// powers of two and HASH_W >= IDX_W.
module express_lane_steer
    import xl_pkg::*;
#(
    parameter int DESC_W     = 32,
    parameter int HASH_W     = 16,
    parameter int IDX_W      = 4,
    parameter int CNT_W      = 8,
    parameter int AGE_W      = 16,
    parameter int EXP_DEPTH  = 4,
    parameter int NORM_DEPTH = 8,
    parameter int STAT_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [DESC_W-1:0]                 in_desc,
    input  logic [HASH_W-1:0]                 in_hash,
    input  logic [CNT_W-1:0]                  prio_threshold,
    input  logic [AGE_W-1:0]                  idle_limit,
    input  logic                              out_ready,
    output logic                              out_valid,
    output logic [DESC_W-1:0]                 out_desc,
    output logic                              out_express,
    output logic [$clog2(EXP_DEPTH+1)-1:0]    exp_occ,
    output logic [$clog2(NORM_DEPTH+1)-1:0]   norm_occ,
    output logic [STAT_W-1:0]                 exp_sent,
    output logic [STAT_W-1:0]                 norm_sent
);
    logic [IDX_W-1:0]  idx;
    logic              accept, qualify;
    logic              exp_push, norm_push, exp_pop, norm_pop;
    logic              exp_empty, exp_full, norm_empty, norm_full;
    logic [DESC_W-1:0] exp_head, norm_head;
    lane_e             out_lane;

    // Fold every hash bit into the table index.
    always_comb begin
        idx = '0;
        for (int b = 0; b < HASH_W; b++) begin
            idx[b % IDX_W] = idx[b % IDX_W] ^ in_hash[b];
        end
    end

    // Admission and lane steering.
    always_comb begin
        in_ready  = !norm_full;
        accept    = in_valid && in_ready;
        exp_push  = accept && qualify && !exp_full;
        norm_push = accept && !exp_push;
    end

    xl_flow_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .AGE_W(AGE_W)) u_table (
        .clk(clk), .rst_n(rst_n), .lookup(accept), .idx(idx),
        .threshold(prio_threshold), .idle_limit(idle_limit), .qualify(qualify)
    );

    xl_fifo #(.W(DESC_W), .DEPTH(EXP_DEPTH)) u_exp_fifo (
        .clk(clk), .rst_n(rst_n), .push(exp_push), .din(in_desc),
        .pop(exp_pop), .dout(exp_head), .empty(exp_empty), .full(exp_full),
        .occ(exp_occ)
    );

    xl_fifo #(.W(DESC_W), .DEPTH(NORM_DEPTH)) u_norm_fifo (
        .clk(clk), .rst_n(rst_n), .push(norm_push), .din(in_desc),
        .pop(norm_pop), .dout(norm_head), .empty(norm_empty), .full(norm_full),
        .occ(norm_occ)
    );

    xl_sched #(.W(DESC_W)) u_sched (
        .exp_empty(exp_empty), .norm_empty(norm_empty),
        .exp_head(exp_head), .norm_head(norm_head), .out_ready(out_ready),
        .out_valid(out_valid), .out_desc(out_desc), .out_lane(out_lane),
        .exp_pop(exp_pop), .norm_pop(norm_pop)
    );

    assign out_express = (out_lane == LANE_EXPRESS);

    // Per-lane placement counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_sent  <= '0;
            norm_sent <= '0;
        end else begin
            if (exp_push)  exp_sent  <= exp_sent + STAT_W'(1);
            if (norm_push) norm_sent <= norm_sent + STAT_W'(1);
        end
    end

    p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({exp_push, norm_push}) <= 1);
    p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && qualify && exp_full) |-> norm_push);
    p_express_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_express) |-> (exp_occ == '0));
    p_no_accept_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (norm_occ == NORM_DEPTH[$clog2(NORM_DEPTH+1)-1:0])) |=>
            $stable(exp_sent) && $stable(norm_sent));
endmodule

// File: tb/express_lane_steer_test.sv
`timescale 1ns/1ps
// Directed bench for the express-lane prioritizer.
module express_lane_steer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_desc = '0;
    logic [15:0] in_hash = '0;
    logic [7:0]  prio_threshold = 8'd3;
    logic [15:0] idle_limit = 16'd1000;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_desc;
    logic        out_express;
    logic [2:0]  exp_occ;
    logic [3:0]  norm_occ;
    logic [15:0] exp_sent, norm_sent;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    express_lane_steer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .in_hash(in_hash), .prio_threshold(prio_threshold),
        .idle_limit(idle_limit), .out_ready(out_ready), .out_valid(out_valid),
        .out_desc(out_desc), .out_express(out_express), .exp_occ(exp_occ),
        .norm_occ(norm_occ), .exp_sent(exp_sent), .norm_sent(norm_sent)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One-cycle packet offer, starting and ending at a negedge.
    task automatic send(input logic [15:0] h, input logic [31:0] d);
        in_valid = 1'b1; in_hash = h; in_desc = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Take one descriptor and check it.
    task automatic pop_one(input string req, input logic [31:0] d, input logic xp);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "out_desc", out_desc, d);
        chk(req, "out_express", out_express, xp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        for (int k = 0; k < 64 && out_valid; k++) @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "exp_occ", exp_occ, 0);
        chk("R1", "norm_occ", norm_occ, 0);
        chk("R1", "exp_sent", exp_sent, 0);
        chk("R1", "norm_sent", norm_sent, 0);
    endtask

    task automatic t_threshold();
        prio_threshold = 8'd3;
        for (int k = 0; k < 5; k++) send(16'h0001, 32'd100 + k);
        chk("R2", "exp_occ", exp_occ, 3);
        chk("R2", "norm_occ", norm_occ, 2);
        chk("R9", "exp_sent", exp_sent, 3);
        chk("R9", "norm_sent", norm_sent, 2);
        for (int k = 0; k < 3; k++) pop_one("R4", 32'd100 + k, 1'b1);
        for (int k = 3; k < 5; k++) pop_one("R4", 32'd100 + k, 1'b0);
        chk("R9", "norm_occ empty", norm_occ, 0);
    endtask

    task automatic t_priority();
        send(16'h0001, 32'd200);
        send(16'h0001, 32'd201);
        send(16'h0002, 32'd202);
        pop_one("R3", 32'd202, 1'b1);
        pop_one("R3", 32'd200, 1'b0);
        pop_one("R3", 32'd201, 1'b0);
    endtask

    task automatic t_saturate();
        logic [15:0] e0, n0;
        e0 = exp_sent; n0 = norm_sent;
        prio_threshold = 8'd3;
        for (int k = 0; k < 5; k++) send(16'h0003, 32'd250 + k);
        prio_threshold = 8'd5;
        send(16'h0003, 32'd260);
        chk("R5", "express placed", exp_sent - e0, 4);
        chk("R5", "normal placed", norm_sent - n0, 2);
        drain();
        prio_threshold = 8'd3;
    endtask

    task automatic t_fallback();
        for (int k = 0; k < 6; k++) send(16'h0008 + 16'(k), 32'h300 + k);
        chk("R7", "exp_occ full", exp_occ, 4);
        chk("R7", "norm_occ fallback", norm_occ, 2);
        for (int k = 0; k < 4; k++) pop_one("R7", 32'h300 + k, 1'b1);
        for (int k = 4; k < 6; k++) pop_one("R7", 32'h300 + k, 1'b0);
    endtask

    task automatic t_aging();
        logic [15:0] e0, n0;
        idle_limit = 16'd20;
        prio_threshold = 8'd2;
        send(16'h000E, 32'd400);
        send(16'h000E, 32'd401);
        e0 = exp_sent; n0 = norm_sent;
        repeat (19) @(negedge clk);
        send(16'h000E, 32'd402);
        chk("R6", "kept at limit, normal", norm_sent - n0, 1);
        chk("R6", "kept at limit, no express", exp_sent - e0, 0);
        repeat (20) @(negedge clk);
        send(16'h000E, 32'd403);
        chk("R6", "cleared past limit, express", exp_sent - e0, 1);
        drain();
        idle_limit = 16'd1000;
        prio_threshold = 8'd3;
    endtask

    task automatic t_concurrent();
        prio_threshold = 8'd0;
        out_ready = 1'b1;
        in_valid = 1'b1;
        in_hash = 16'h0005;
        for (int k = 0; k < 6; k++) begin
            in_desc = 32'd500 + k;
            @(negedge clk);
            chk("R10", "norm_occ steady", norm_occ, 1);
            chk("R10", "head order", out_desc, 32'd500 + k);
        end
        in_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10", "drained", out_valid, 0);
        prio_threshold = 8'd3;
    endtask

    task automatic t_backpressure();
        logic [15:0] e0, n0;
        prio_threshold = 8'd0;
        for (int k = 0; k < 8; k++) send(16'h0006, 32'd600 + k);
        chk("R8", "norm_occ full", norm_occ, 8);
        chk("R8", "in_ready low", in_ready, 0);
        e0 = exp_sent; n0 = norm_sent;
        prio_threshold = 8'd3;
        send(16'h0007, 32'd699);
        chk("R8", "norm_occ unchanged", norm_occ, 8);
        chk("R8", "exp_occ unchanged", exp_occ, 0);
        chk("R8", "counters unchanged", {exp_sent - e0, norm_sent - n0}, 0);
        pop_one("R8", 32'd600, 1'b0);
        chk("R8", "in_ready back", in_ready, 1);
        drain();
        send(16'h0007, 32'd700);
        chk("R8", "ignored offer left flow fresh", exp_sent - e0, 1);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_priority();
        t_saturate();
        t_fallback();
        t_aging();
        t_concurrent();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule